// File: doc/BRIEF.md
# Accelerator completion interrupt unit

This unit gathers the completion and fault events of a multichannel FIR filter accelerator and turns them into two level interrupt lines. The accelerator's sequencer sends single-cycle pulses when one channel's output window has been computed and its indices written back, and when a whole pass over all channels (or one round of time slots) has finished. Each of the MAC units also sends a pulse when a fixed-point or floating-point operation raises an arithmetic exception.

A mode bit in a small control register picks which completion pulse counts as the DMA interrupt condition. When the chosen pulse arrives, both completion status bits are set together. Software reads the DMA status register to see and clear both bits. Exceptions are latched in one sticky flag per MAC unit, so a read of the MAC status register shows which unit faulted and clears all the flags. The DMA interrupt stays high while a completion bit is set. The MAC interrupt stays high while any exception flag is set. If an event lands in the same cycle as the read that clears its status, the event wins and nothing is lost.

Top module: `accel_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, all status bits, the mode bit and the read data register are 0, and both interrupt lines are low.
- R2: A write to address 0 stores `reg_wr_bit` as the mode bit (0 = window-complete drives the DMA interrupt, 1 = all-channels-complete drives it). A read of address 0 returns the mode in bit 0.
- R3: In mode 0, a `win_done_evt` pulse sets both the window-done bit (address 1, bit 0) and the all-done bit (address 1, bit 1) at the next clock edge.
- R4: In mode 1, an `all_done_evt` pulse sets both completion bits at the next clock edge.
- R5: A completion pulse that the mode does not select leaves both completion bits unchanged.
- R6: A read of address 1 returns the two completion bits on `reg_rd_data` in the cycle after the read strobe and clears both bits.
- R7: `dma_irq` is high exactly while a completion bit is set.
- R8: A pulse on `mac_exc_evt[i]` sets the sticky flag of MAC unit i, visible at address 2, bit i. Flags of other units are not affected.
- R9: `mac_irq` is high exactly while any MAC exception flag is set.
- R10: A read of address 2 returns the MAC flags and clears all of them.
- R11: An event in the same cycle as a clearing read leaves its status bit set afterward, and the read returns the value from before the event.
- R12: Reads of address 0 and of the unused address 3 clear nothing. Address 3 reads as 0. Writes to addresses other than 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_done_evt | input | 1 | Pulse: one channel's window finished |
| all_done_evt | input | 1 | Pulse: all channels or one time-slot round finished |
| mac_exc_evt | input | NUM_MAC | Pulse per MAC unit: arithmetic exception |
| reg_addr | input | 2 | Register address (0 control, 1 DMA status, 2 MAC status) |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_bit | input | 1 | Write data, the mode bit |
| reg_rd_en | input | 1 | Read strobe; clears the addressed status register |
| reg_rd_data | output | DATA_W | Registered read data, valid the cycle after the strobe |
| dma_irq | output | 1 | Completion interrupt level |
| mac_irq | output | 1 | MAC exception interrupt level |

## Verification
The set path and the read-clear path can hit the same status register in the same cycle. A selected completion pulse can coincide with a read of address 1, and an exception pulse can coincide with a read of address 2. The bench forces both collisions directly, and its random traffic also makes them happen by chance. It judges each one against a model that applies the clear first and then the set: the read must return the value from before the event, and the interrupt line must stay high afterward.

// File: rtl/accel_irq_pkg.sv
// Package: register addresses and sizing shared by the interrupt unit.
// Assumes a two-bit register address space.
package accel_irq_pkg;
    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_DMA_ST = 2'd1,
        REG_MAC_ST = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    localparam int DONE_BITS = 2;
endpackage

// File: rtl/irq_ctrl_reg.sv
// Module: holds the completion-source mode bit.
// Assumes the write strobe is already decoded for the control address.
module irq_ctrl_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic mode_q
);
    // Load the mode bit on a decoded write; reset selects window mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 1'b0;
        else if (wr_en)
            mode_q <= wr_bit;
    end
endmodule

// File: rtl/irq_done_status.sv
// Module: keeps the paired completion status bits and the DMA interrupt.
// Assumes event inputs are single-cycle pulses; a set beats a clear.
module irq_done_status (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_all,
    input  logic win_evt,
    input  logic all_evt,
    input  logic clr,
    output logic win_q,
    output logic all_q,
    output logic irq
);
    logic hit;

    // Pick the completion event that the mode bit selects.
    always_comb begin
        hit = mode_all ? all_evt : win_evt;
    end

    // Window-done bit: set on a selected event, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_q <= 1'b0;
        else if (hit)
            win_q <= 1'b1;
        else if (clr)
            win_q <= 1'b0;
    end

    // All-done bit: same set and clear rule as its partner.
    always_ff @(posedge clk) begin
        if (!rst_n)
            all_q <= 1'b0;
        else if (hit)
            all_q <= 1'b1;
        else if (clr)
            all_q <= 1'b0;
    end

    // The level interrupt follows either status bit.
    always_comb begin
        irq = win_q | all_q;
    end
endmodule

// File: rtl/irq_mac_status.sv
// Module: one sticky exception flag per MAC unit and the OR interrupt.
// Assumes exception inputs are pulses; a set beats a clear.
module irq_mac_status #(
    parameter int NUM_MAC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MAC-1:0] exc,
    input  logic               clr,
    output logic [NUM_MAC-1:0] flags_q,
    output logic               irq
);
    genvar g;
    generate
        for (g = 0; g < NUM_MAC; g++) begin : g_flag
            // Flag g latches its unit's exception until a status read.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flags_q[g] <= 1'b0;
                else if (exc[g])
                    flags_q[g] <= 1'b1;
                else if (clr)
                    flags_q[g] <= 1'b0;
            end
        end
    endgenerate

    // The level interrupt follows any flag.
    always_comb begin
        irq = |flags_q;
    end
endmodule

// File: rtl/accel_irq_unit.sv
// Module: top of the accelerator completion interrupt unit. Decodes the
// register port, clears status on reads and registers the read data.
// Assumes DATA_W is at least NUM_MAC and at least two.
module accel_irq_unit
    import accel_irq_pkg::*;
#(
    parameter int NUM_MAC = 4,
    parameter int DATA_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  win_done_evt,
    input  logic                  all_done_evt,
    input  logic [NUM_MAC-1:0]    mac_exc_evt,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_wr_en,
    input  logic                  reg_wr_bit,
    input  logic                  reg_rd_en,
    output logic [DATA_W-1:0]     reg_rd_data,
    output logic                  dma_irq,
    output logic                  mac_irq
);
    localparam int PAD_DONE = DATA_W - DONE_BITS;
    localparam int PAD_MAC  = DATA_W - NUM_MAC;

    logic               mode_q;
    logic               ctrl_wr;
    logic               dma_clr;
    logic               mac_clr;
    logic               win_q;
    logic               all_q;
    logic [NUM_MAC-1:0] mac_flags;
    logic [DATA_W-1:0]  rd_next;

    // Decode writes and clearing reads from the register address.
    always_comb begin
        ctrl_wr = reg_wr_en && (reg_addr == REG_CTRL);
        dma_clr = reg_rd_en && (reg_addr == REG_DMA_ST);
        mac_clr = reg_rd_en && (reg_addr == REG_MAC_ST);
    end

    irq_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctrl_wr),
        .wr_bit (reg_wr_bit),
        .mode_q (mode_q)
    );

    irq_done_status u_done (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_all (mode_q),
        .win_evt  (win_done_evt),
        .all_evt  (all_done_evt),
        .clr      (dma_clr),
        .win_q    (win_q),
        .all_q    (all_q),
        .irq      (dma_irq)
    );

    irq_mac_status #(.NUM_MAC(NUM_MAC)) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .exc     (mac_exc_evt),
        .clr     (mac_clr),
        .flags_q (mac_flags),
        .irq     (mac_irq)
    );

    // Select the value of the addressed register, zero-extended.
    always_comb begin
        case (reg_sel_e'(reg_addr))
            REG_CTRL:   rd_next = {{(DATA_W-1){1'b0}}, mode_q};
            REG_DMA_ST: rd_next = {{PAD_DONE{1'b0}}, all_q, win_q};
            REG_MAC_ST: rd_next = {{PAD_MAC{1'b0}}, mac_flags};
            default:    rd_next = '0;
        endcase
    end

    // Capture the read value on a read strobe, from before any clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rd_data <= '0;
        else if (reg_rd_en)
            reg_rd_data <= rd_next;
    end
endmodule

// File: rtl/accel_irq_unit_chk.sv
// Checker: temporal properties of the interrupt unit, bound to the top.
// Assumes single-cycle event pulses and the address map of the package.
module accel_irq_unit_chk #(
    parameter int NUM_MAC = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mode_q,
    input logic               win_done_evt,
    input logic               all_done_evt,
    input logic [NUM_MAC-1:0] mac_exc_evt,
    input logic [1:0]         reg_addr,
    input logic               reg_rd_en,
    input logic               dma_irq,
    input logic               mac_irq
);
    logic sel_evt;
    logic oth_evt;

    // Work out the selected and unselected completion events from the ports.
    always_comb begin
        sel_evt = mode_q ? all_done_evt : win_done_evt;
        oth_evt = mode_q ? win_done_evt : all_done_evt;
    end

    AST_SEL_EVENT_RAISES_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        sel_evt |=> dma_irq); // R3

    AST_UNSEL_EVENT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_irq && oth_evt && !sel_evt) |=> !dma_irq); // R5

    AST_DMA_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr == 2'd1 && !sel_evt) |=> !dma_irq); // R6

    AST_DMA_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr == 2'd1 && sel_evt) |=> dma_irq); // R11

    AST_MAC_EXC_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (|mac_exc_evt) |=> mac_irq); // R9

    AST_MAC_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr == 2'd2 && mac_exc_evt == '0) |=> !mac_irq); // R10

    AST_DMA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_irq && !(reg_rd_en && reg_addr == 2'd1)) |=> dma_irq); // R7

    AST_MAC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_irq && !(reg_rd_en && reg_addr == 2'd2)) |=> mac_irq); // R9
endmodule

bind accel_irq_unit accel_irq_unit_chk #(.NUM_MAC(NUM_MAC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_q       (mode_q),
    .win_done_evt (win_done_evt),
    .all_done_evt (all_done_evt),
    .mac_exc_evt  (mac_exc_evt),
    .reg_addr     (reg_addr),
    .reg_rd_en    (reg_rd_en),
    .dma_irq      (dma_irq),
    .mac_irq      (mac_irq)
);

// File: tb/sim_accel_irq_unit.sv
`timescale 1ns/1ps
module sim_accel_irq_unit;
    localparam int NM = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          win_done_evt = 1'b0;
    logic          all_done_evt = 1'b0;
    logic [NM-1:0] mac_exc_evt = '0;
    logic [1:0]    reg_addr = '0;
    logic          reg_wr_en = 1'b0;
    logic          reg_wr_bit = 1'b0;
    logic          reg_rd_en = 1'b0;
    logic [DW-1:0] reg_rd_data;
    logic          dma_irq;
    logic          mac_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Bench model of the register state.
    logic          m_mode = 1'b0;
    logic          m_win = 1'b0;
    logic          m_all = 1'b0;
    logic [NM-1:0] m_mac = '0;

    always #2 clk = ~clk;

    accel_irq_unit #(.NUM_MAC(NM), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .win_done_evt(win_done_evt), .all_done_evt(all_done_evt),
        .mac_exc_evt(mac_exc_evt), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wr_bit(reg_wr_bit),
        .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data),
        .dma_irq(dma_irq), .mac_irq(mac_irq)
    );

    function automatic logic [DW-1:0] model_read(input logic [1:0] a);
        logic [DW-1:0] v = '0;
        case (a)
            2'd0: v[0] = m_mode;
            2'd1: v[1:0] = {m_all, m_win};
            2'd2: v[NM-1:0] = m_mac;
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle of stimulus, model update and checks at the next negedge.
    task automatic step(input string req, input logic w, input logic a, input logic [NM-1:0] e,
                        input logic wr, input logic wb, input logic rd, input logic [1:0] ad);
        logic sel;
        logic [DW-1:0] exp_rd;
        win_done_evt = w; all_done_evt = a; mac_exc_evt = e;
        reg_wr_en = wr; reg_wr_bit = wb; reg_rd_en = rd; reg_addr = ad;
        sel = m_mode ? a : w;
        exp_rd = model_read(ad);
        if (rd && ad == 2'd1) begin m_win = 1'b0; m_all = 1'b0; end
        if (sel) begin m_win = 1'b1; m_all = 1'b1; end
        if (rd && ad == 2'd2) m_mac = '0;
        m_mac = m_mac | e;
        if (wr && ad == 2'd0) m_mode = wb;
        @(posedge clk);
        @(negedge clk);
        win_done_evt = 1'b0; all_done_evt = 1'b0; mac_exc_evt = '0;
        reg_wr_en = 1'b0; reg_rd_en = 1'b0;
        check({req, " dma_irq"}, {31'b0, dma_irq}, {31'b0, m_win | m_all});
        check({req, " mac_irq"}, {31'b0, mac_irq}, {31'b0, |m_mac});
        if (rd) check({req, " rd_data"}, reg_rd_data, exp_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 dma_irq", {31'b0, dma_irq}, '0);
        check("R1 mac_irq", {31'b0, mac_irq}, '0);
        check("R1 rd_data", reg_rd_data, '0);
        step("R1", 0, 0, '0, 0, 0, 1, 2'd0);
        // R3: window event in mode 0 sets both bits
        step("R3", 1, 0, '0, 0, 0, 0, 2'd0);
        step("R3", 0, 0, '0, 0, 0, 1, 2'd1);  // R6 read clears
        step("R6", 0, 0, '0, 0, 0, 1, 2'd1);
        // R5: all-done ignored in mode 0
        step("R5", 0, 1, '0, 0, 0, 0, 2'd0);
        step("R5", 0, 0, '0, 0, 0, 1, 2'd1);
        // R2: set mode 1 and read it back
        step("R2", 0, 0, '0, 1, 1, 0, 2'd0);
        step("R2", 0, 0, '0, 0, 0, 1, 2'd0);
        // R4: all-done in mode 1; R5 window ignored
        step("R5", 1, 0, '0, 0, 0, 0, 2'd0);
        step("R4", 0, 1, '0, 0, 0, 0, 2'd0);
        step("R7", 0, 0, '0, 0, 0, 1, 2'd0);  // R12 read of ctrl clears nothing
        step("R12", 0, 0, '0, 0, 0, 1, 2'd3);
        step("R12", 0, 0, '0, 1, 0, 0, 2'd1); // write to status has no effect
        // R11: selected event colliding with a clearing read
        step("R11", 0, 1, '0, 0, 0, 1, 2'd1);
        step("R11", 0, 0, '0, 0, 0, 1, 2'd1);
        // R8: each MAC unit sets only its own flag
        for (int i = 0; i < NM; i++) begin
            step("R8", 0, 0, NM'(1 << i), 0, 0, 0, 2'd0);
            step("R8", 0, 0, '0, 0, 0, 1, 2'd2);  // R10 clears
        end
        // R11 on the MAC flags; R9 level
        step("R9", 0, 0, 4'b0101, 0, 0, 0, 2'd0);
        step("R11", 0, 0, 4'b1000, 0, 0, 1, 2'd2);
        step("R10", 0, 0, '0, 0, 0, 1, 2'd2);
        // Random traffic mixing all functions
        for (int k = 0; k < 3000; k++) begin
            logic [NM-1:0] e;
            e = (($urandom % 6) == 0) ? NM'($urandom) : '0;
            step("RND", ($urandom % 4) == 0, ($urandom % 5) == 0, e,
                 ($urandom % 10) == 0, 1'($urandom), ($urandom % 3) == 0, 2'($urandom));
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule